// File: doc/BRIEF.md
# Supply Shutdown and Remote Sequencer

This block is the digital housekeeping controller on the secondary side of a switched-mode supply. It drives one active-high `inhibit` output that shuts down the main converter. Two things can raise it. The first is a remote on/off request: it passes through a two-flop synchronizer and then a delay path with different lengths for each direction. A high request, meaning off, takes effect after a short delay. A low request, meaning on, takes effect after a longer delay, nominally three times as long. The second is a sticky fault latch. Over-voltage flags for three rails, an extra protection flag and under-voltage flags for the same three rails all set this latch.

Under-voltage flags are masked during a blank-out window. The window is armed at reset and re-armed by a start-up pulse, so rails that are still ramping cannot trip the latch. The only way to clear the latch is the delayed remote-high signal. To restart after a fault, the remote request must therefore go high for the on-delay and then low again for the off-delay. All lengths are parameters counted in clock cycles, and all comparator results arrive as synchronous flags.

Top module: `supply_shutdown_seq`

## Requirements
- R1: While reset is asserted, and right after it, `inhibit` is 1, the fault latch is clear and the under-voltage blank-out window is armed for BLANK_CYC cycles.
- R2: After `remote_off_req` rises and stays high, `inhibit` rises exactly ON_DLY_CYC+2 clock edges after the change: 2 edges for synchronization plus ON_DLY_CYC for the delay.
- R3: After `remote_off_req` falls and stays low, with the fault latch clear, `inhibit` falls exactly OFF_DLY_CYC+2 clock edges after the change.
- R4: If the synchronized request returns to the current delayed level before its delay has elapsed, the pending count is discarded. A pulse shorter than the delay never reaches `inhibit`. A later change restarts the count from zero.
- R5: A 1 on any bit of `ov_flag` sets the fault latch. Bit 0 is the 3.3 V rail, bit 1 the 5 V rail and bit 2 the 12 V rail. A 1 on `ext_prot` also sets it. `inhibit` is 1 from the next edge on, and stays 1 after the flag drops.
- R6: A 1 on any bit of `uv_flag` sets the fault latch when the blank-out window is not active. The bit order is the same as for `ov_flag`.
- R7: While the blank-out window is active, `uv_flag` has no effect. A 1 on `startup_pulse` re-arms the window for BLANK_CYC cycles. Over-voltage and `ext_prot` flags are never masked.
- R8: Only the delayed remote-high level clears the fault latch. Remote low on its own keeps `inhibit` high after a fault. After a high-then-low remote sequence, `inhibit` returns to 0.
- R9: If the latch is set and cleared in the same cycle, the clear wins. `inhibit` stays 1 through the delayed remote-high level. A later remote low then releases `inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| remote_off_req | input | 1 | Remote request; 1 asks for the converter to be off (asynchronous) |
| startup_pulse | input | 1 | Re-arms the under-voltage blank-out window |
| ov_flag | input | RAILS | Over-voltage comparator flags, bit 0 = 3.3 V, bit 1 = 5 V, bit 2 = 12 V |
| ext_prot | input | 1 | Extra protection flag |
| uv_flag | input | RAILS | Under-voltage comparator flags, same bit order as ov_flag |
| inhibit | output | 1 | 1 turns the main converter off |

## Verification
The bench targets the exact edge at which each delay completes, by sampling one cycle before and at the expected edge. A design with an off-by-one counter, or a missing or extra synchronizer stage, would move `inhibit` one cycle early or late. The bench sends remote pulses shorter than the delay, and reversals in the middle of a pending delay. A design that does not discard the partial count would either let the glitch through or shorten the following delay. It checks that under-voltage flags are ignored both just after reset and after a start-up pulse, while over-voltage flags still trip. It also presents a fault while the latch is being cleared. A design that lets the set win would keep `inhibit` high after the remote goes low.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
    localparam int RAILS = 3;

    // Index of each monitored rail inside the flag vectors
    typedef enum int {
        RAIL_3V3 = 0,
        RAIL_5V  = 1,
        RAIL_12V = 2
    } rail_e;
endpackage

// File: rtl/remote_delay.sv
module remote_delay #(
    parameter int ON_CYC  = 8000,
    parameter int OFF_CYC = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic dly_o
);
    localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] MAX_LAST = CW'(MAX_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          dly;
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = req_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.dly) begin
            // no change pending, or a reversal: drop any partial count
            st_d.cnt = '0;
        end else if (st_q.cnt == (st_q.s2 ? ON_LAST : OFF_LAST)) begin
            st_d.dly = st_q.s2;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, dly: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_o = st_q.dly;

    // R2 / R3: the counter never passes the longest programmed delay
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= MAX_LAST);

    // R4: the delayed level only ever moves toward the synchronized level
    p_dly_follows_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2 == st_q.dly) |=> $stable(st_q.dly));
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
    parameter int BLANK_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o = (cnt_q != '0);

    // R7: a start-up pulse always opens the window on the next cycle
    p_arm_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ov_i,
    input  logic         ext_i,
    input  logic [N-1:0] uv_i,
    input  logic         uv_mask_i,
    input  logic         clr_i,
    output logic         flt_o
);
    logic set;
    logic flt_d, flt_q;

    always_comb begin
        set   = (|ov_i) | ext_i | ((|uv_i) & ~uv_mask_i);
        flt_d = flt_q;
        if (clr_i) begin
            flt_d = 1'b0;          // clear has priority over set
        end else if (set) begin
            flt_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= 1'b0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign flt_o = flt_q;

    // R5: an over-voltage or extra protection flag trips the latch
    p_ov_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ov_i || ext_i) && !clr_i) |=> flt_o);

    // R7: an under-voltage flag inside the window leaves a clear latch clear
    p_uv_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_o && uv_mask_i && !(|ov_i) && !ext_i) |=> !flt_o);

    // R9: clear wins over a simultaneous set
    p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flt_o);

    // R8: nothing but the clear releases a set latch
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_o && !clr_i) |=> flt_o);
endmodule

// File: rtl/supply_shutdown_seq.sv
module supply_shutdown_seq
    import shdn_pkg::*;
#(
    parameter int ON_DLY_CYC  = 8000,
    parameter int OFF_DLY_CYC = 24000,
    parameter int BLANK_CYC   = 250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             remote_off_req,
    input  logic             startup_pulse,
    input  logic [RAILS-1:0] ov_flag,
    input  logic             ext_prot,
    input  logic [RAILS-1:0] uv_flag,
    output logic             inhibit
);
    logic remote_dly;
    logic blank_on;
    logic fault;

    remote_delay #(
        .ON_CYC  (ON_DLY_CYC),
        .OFF_CYC (OFF_DLY_CYC)
    ) u_remote (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (remote_off_req),
        .dly_o (remote_dly)
    );

    blank_timer #(
        .BLANK_CYC (BLANK_CYC)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (startup_pulse),
        .active_o (blank_on)
    );

    fault_latch #(
        .N (RAILS)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ov_i      (ov_flag),
        .ext_i     (ext_prot),
        .uv_i      (uv_flag),
        .uv_mask_i (blank_on),
        .clr_i     (remote_dly),
        .flt_o     (fault)
    );

    assign inhibit = remote_dly | fault;
endmodule

// File: tb/supply_shutdown_seq_tb_top.sv
module supply_shutdown_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ON_C    = 8;
    localparam int OFF_C   = 24;
    localparam int BLANK_C = 40;

    // {ov[2:0], ext, uv[2:0], expected inhibit}
    localparam logic [7:0] VEC [8] = '{
        8'b001_0_000_1, 8'b010_0_000_1, 8'b100_0_000_1, 8'b000_1_000_1,
        8'b000_0_001_1, 8'b000_0_010_1, 8'b000_0_100_1, 8'b000_0_000_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       remote_off_req = 1'b1;
    logic       startup_pulse = 1'b0;
    logic [2:0] ov_flag = '0;
    logic       ext_prot = 1'b0;
    logic [2:0] uv_flag = '0;
    logic       inhibit;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supply_shutdown_seq #(
        .ON_DLY_CYC  (ON_C),
        .OFF_DLY_CYC (OFF_C),
        .BLANK_CYC   (BLANK_C)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .remote_off_req (remote_off_req),
        .startup_pulse  (startup_pulse),
        .ov_flag        (ov_flag),
        .ext_prot       (ext_prot),
        .uv_flag        (uv_flag),
        .inhibit        (inhibit)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (inhibit !== exp) begin
            errors++;
            $display("FAIL %s: inhibit actual %b expected %b", tag, inhibit, exp);
        end
    endtask

    // Clear the latch and bring the converter back on (R8)
    task automatic restart();
        remote_off_req = 1'b1;
        step(ON_C + 3);
        remote_off_req = 1'b0;
        step(OFF_C + 3);
    endtask

    initial begin
        step(3);
        check(1'b1, "R1 inhibit in reset");
        rst_n = 1'b1;
        step(1);
        check(1'b1, "R1 inhibit after reset");

        remote_off_req = 1'b0;
        step(OFF_C + 1);
        check(1'b1, "R3 off delay not yet done");
        step(1);
        check(1'b0, "R3 off delay done");

        uv_flag = 3'b001;
        step(3);
        check(1'b0, "R1 blank window armed by reset");
        uv_flag = '0;

        startup_pulse = 1'b1;
        step(1);
        startup_pulse = 1'b0;
        uv_flag = 3'b010;
        step(5);
        check(1'b0, "R7 uv masked after startup pulse");
        step(BLANK_C + 2);
        check(1'b1, "R6 uv trips after window");
        uv_flag = '0;
        restart();
        check(1'b0, "R8 restart after uv fault");

        ov_flag = 3'b100;
        step(1);
        ov_flag = '0;
        step(5);
        check(1'b1, "R5 latch holds after flag drops");
        step(OFF_C + 5);
        check(1'b1, "R8 remote low alone does not clear");
        restart();
        check(1'b0, "R8 restart after ov fault");

        for (int i = 0; i < 8; i++) begin
            ov_flag  = VEC[i][7:5];
            ext_prot = VEC[i][4];
            uv_flag  = VEC[i][3:1];
            step(1);
            ov_flag  = '0;
            ext_prot = 1'b0;
            uv_flag  = '0;
            check(VEC[i][0], (VEC[i][3:1] != 0) ? "R6 table entry" : "R5 table entry");
            step(3);
            check(VEC[i][0], "R5 table entry held");
            if (VEC[i][0]) begin
                restart();
                check(1'b0, "R8 table restart");
            end
        end

        remote_off_req = 1'b1;
        step(ON_C + 1);
        check(1'b0, "R2 on delay not yet done");
        step(1);
        check(1'b1, "R2 on delay done");
        remote_off_req = 1'b0;
        step(OFF_C + 1);
        check(1'b1, "R3 second off not yet done");
        step(1);
        check(1'b0, "R3 second off done");

        begin
            int seen_high = 0;
            remote_off_req = 1'b1;
            step(ON_C / 2);
            remote_off_req = 1'b0;
            for (int k = 0; k < ON_C + 6; k++) begin
                step(1);
                if (inhibit) seen_high++;
            end
            checks++;
            if (seen_high != 0) begin
                errors++;
                $display("FAIL R4: short pulse reached inhibit %0d cycles, expected 0", seen_high);
            end
        end

        remote_off_req = 1'b1;
        step(ON_C + 3);
        remote_off_req = 1'b0;
        step(10);
        remote_off_req = 1'b1;
        step(4);
        remote_off_req = 1'b0;
        step(OFF_C + 1);
        check(1'b1, "R4 reversal restarts off count");
        step(1);
        check(1'b0, "R4 off after restarted count");

        remote_off_req = 1'b1;
        step(ON_C + 3);
        ov_flag = 3'b010;
        step(3);
        check(1'b1, "R9 inhibit high while clear and set meet");
        ov_flag = '0;
        remote_off_req = 1'b0;
        step(OFF_C + 2);
        check(1'b0, "R9 clear won over set");

        startup_pulse = 1'b1;
        step(1);
        startup_pulse = 1'b0;
        ov_flag = 3'b001;
        step(1);
        ov_flag = '0;
        check(1'b1, "R7 ov not masked in window");
        restart();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run not finished, actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule